// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps an effective address to a physical address through a small file of large-block translation entries. Two independent banks are kept: one consulted for instruction fetches, the other for data accesses. Each entry carries a block mask, an effective-page field, a real-page field, a user-valid and a supervisor-valid bit, and a two-bit protection code. A lookup compares the masked address against every eligible entry of the chosen bank at once, drops matches that refuse the requested kind of access, and reports the lowest-numbered survivor.

Entries are loaded through a one-entry-per-cycle write port. A lookup is presented on one cycle and answered from a register on the next, with a hit flag, the physical address, the read/write/execute rights and a virtual page tag built from the caller's segment identifier and the page bits of the address. Page-table walks and segment registers live outside this unit.

Top module: `bat_xlate_unit`

## Requirements
- R1: After reset every entry of both banks is invalid, so any lookup misses, and `rsp_valid` is 0.
- R2: `lk_data`=1 searches the data bank (write-port bank 1); `lk_data`=0 searches the instruction bank (write-port bank 0). Entries of the other bank never hit.
- R3: With `lk_user`=1 an entry is eligible only if its user-valid bit is set; with `lk_user`=0 only if its supervisor-valid bit is set.
- R4: An eligible entry matches when (`lk_addr` AND mask) equals its effective-page field.
- R5: On a hit, `rsp_paddr` is the entry's real-page field ORed with the address bits that are 0 in the mask.
- R6: Protection code 0 grants nothing, 1 grants read only, 2 and 3 grant read and write; `rsp_ex` is 1 on every hit.
- R7: A matching entry whose code is 0, or whose code is 1 when `lk_write`=1, is passed over and the search continues with higher-numbered entries.
- R8: When several entries qualify, the lowest index supplies the result.
- R9: `rsp_vpage` equals {`lk_vsid`, `lk_addr[27:12]`} on every response, hit or miss.
- R10: On a miss, `rsp_hit`, `rsp_rd`, `rsp_wr`, `rsp_ex` are 0 and `rsp_paddr` is 0.
- R11: `rsp_valid` is 1 exactly in the cycle after a cycle with `lk_req`=1, and the response fields belong to that request.
- R12: A write and a lookup in the same cycle: the lookup sees the entries as they stood before the write; the new entry takes part from the next lookup on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load one entry this cycle |
| wr_set | input | 1 | Bank to load: 0 instruction, 1 data |
| wr_idx | input | log2(N_ENT) | Entry index to load |
| wr_mask | input | 32 | Block mask |
| wr_epage | input | 32 | Effective-page field |
| wr_rpage | input | 32 | Real-page field |
| wr_uvld | input | 1 | User-valid bit |
| wr_svld | input | 1 | Supervisor-valid bit |
| wr_prot | input | 2 | Protection code |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Effective address |
| lk_data | input | 1 | 1 data access, 0 instruction fetch |
| lk_write | input | 1 | Access is a store |
| lk_user | input | 1 | 1 user mode, 0 supervisor mode |
| lk_vsid | input | VSID_W | Segment identifier for the page tag |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | An entry translated the address |
| rsp_paddr | output | 32 | Physical address |
| rsp_vpage | output | VSID_W+16 | Virtual page tag |
| rsp_rd | output | 1 | Read allowed |
| rsp_wr | output | 1 | Write allowed |
| rsp_ex | output | 1 | Execute allowed |

## Verification
The entry write port and the lookup path can act in the same cycle, and the unit must resolve that collision with the lookup reading the old contents. The bench loads a fresh entry into the data bank in the very cycle a lookup aimed at that entry's block is presented, expects that response to miss, and then expects an identical lookup one cycle later to hit with the new entry's physical address. A second overlap, a rewrite of an entry's protection code between two lookups, checks that the skip rule follows the stored code at once.

// File: rtl/bat_pkg.sv
// Shared widths and the entry record for the block translation unit.
// Assumes 32-bit effective and physical addresses.
package bat_pkg;
    localparam int ADDR_W   = 32;
    localparam int PROT_W   = 2;
    localparam int PAGE_LO  = 12;
    localparam int PAGE_HI  = 27;
    localparam int VPN_W    = PAGE_HI - PAGE_LO + 1;
    localparam int N_ENT_DEF  = 8;
    localparam int VSID_W_DEF = 24;

    typedef struct packed {
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] epage;
        logic [ADDR_W-1:0] rpage;
        logic              uvld;
        logic              svld;
        logic [PROT_W-1:0] prot;
    } bat_ent_t;
endpackage

// File: rtl/bat_entry_store.sv
// Holds two banks of translation entries (0 instruction, 1 data).
// One entry is written per cycle; the read view is the bank picked by rd_set,
// taken from the registers, so a same-cycle write is not yet visible.
module bat_entry_store
    import bat_pkg::*;
#(
    parameter int N_ENT = N_ENT_DEF,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_set,
    input  logic [IDX_W-1:0]        wr_idx,
    input  bat_ent_t                wr_ent,
    input  logic                    rd_set,
    output bat_ent_t [N_ENT-1:0]    rd_view
);
    for (genvar s = 0; s < 2; s++) begin : g_bank
        bat_ent_t [N_ENT-1:0] ent_q;

        // Clear the bank on reset, otherwise load the addressed entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else if (wr_en && (wr_set == 1'(s))) begin
                ent_q[wr_idx] <= wr_ent;
            end
        end
    end

    // Present the bank chosen by the access type.
    always_comb begin
        rd_view = rd_set ? g_bank[1].ent_q : g_bank[0].ent_q;
    end
endmodule

// File: rtl/bat_match.sv
// Compares one address against every entry of a bank in parallel.
// Flags an entry as qualifying when it is eligible in the current mode,
// its masked compare succeeds and its code permits the access.
module bat_match
    import bat_pkg::*;
#(
    parameter int N_ENT = N_ENT_DEF
) (
    input  bat_ent_t [N_ENT-1:0]              view,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic                              is_write,
    input  logic                              is_user,
    output logic [N_ENT-1:0]                  qual,
    output logic [N_ENT-1:0]                  wr_ok,
    output logic [N_ENT-1:0][ADDR_W-1:0]      pa
);
    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        logic elig, hitm, rd_perm, wr_perm;

        // Evaluate eligibility, compare, rights and physical address of entry i.
        always_comb begin
            elig     = is_user ? view[i].uvld : view[i].svld;
            hitm     = ((addr & view[i].mask) == view[i].epage);
            rd_perm  = (view[i].prot != '0);
            wr_perm  = (view[i].prot > PROT_W'(1));
            qual[i]  = elig && hitm && rd_perm && (!is_write || wr_perm);
            wr_ok[i] = wr_perm;
            pa[i]    = view[i].rpage | (addr & ~view[i].mask);
        end
    end
endmodule

// File: rtl/bat_select.sv
// Picks the lowest-numbered qualifying entry and forwards its results.
// Assumes at most N_ENT candidates; returns zeros when none qualify.
module bat_select
    import bat_pkg::*;
#(
    parameter int N_ENT = N_ENT_DEF
) (
    input  logic [N_ENT-1:0]              qual,
    input  logic [N_ENT-1:0]              wr_ok,
    input  logic [N_ENT-1:0][ADDR_W-1:0]  pa,
    output logic                          hit,
    output logic                          sel_wr,
    output logic [ADDR_W-1:0]             sel_pa
);
    // Scan from the top so the lowest qualifying index is assigned last.
    always_comb begin
        hit    = 1'b0;
        sel_wr = 1'b0;
        sel_pa = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (qual[i]) begin
                hit    = 1'b1;
                sel_wr = wr_ok[i];
                sel_pa = pa[i];
            end
        end
    end
endmodule

// File: rtl/bat_xlate_unit.sv
// Top of the block translation unit: entry store, parallel compare,
// priority pick and a response register one cycle after the request.
// Assumes the caller supplies the segment identifier for the page tag.
module bat_xlate_unit
    import bat_pkg::*;
#(
    parameter int N_ENT  = N_ENT_DEF,
    parameter int VSID_W = VSID_W_DEF,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int VP_W  = VSID_W + VPN_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_set,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [ADDR_W-1:0]   wr_mask,
    input  logic [ADDR_W-1:0]   wr_epage,
    input  logic [ADDR_W-1:0]   wr_rpage,
    input  logic                wr_uvld,
    input  logic                wr_svld,
    input  logic [PROT_W-1:0]   wr_prot,
    input  logic                lk_req,
    input  logic [ADDR_W-1:0]   lk_addr,
    input  logic                lk_data,
    input  logic                lk_write,
    input  logic                lk_user,
    input  logic [VSID_W-1:0]   lk_vsid,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [ADDR_W-1:0]   rsp_paddr,
    output logic [VP_W-1:0]     rsp_vpage,
    output logic                rsp_rd,
    output logic                rsp_wr,
    output logic                rsp_ex
);
    bat_ent_t                       wr_ent;
    bat_ent_t [N_ENT-1:0]           view;
    logic [N_ENT-1:0]               qual;
    logic [N_ENT-1:0]               wr_ok;
    logic [N_ENT-1:0][ADDR_W-1:0]   pa;
    logic                           hit;
    logic                           sel_wr;
    logic [ADDR_W-1:0]              sel_pa;

    // Pack the write-port fields into one entry record.
    always_comb begin
        wr_ent.mask  = wr_mask;
        wr_ent.epage = wr_epage;
        wr_ent.rpage = wr_rpage;
        wr_ent.uvld  = wr_uvld;
        wr_ent.svld  = wr_svld;
        wr_ent.prot  = wr_prot;
    end

    bat_entry_store #(.N_ENT(N_ENT)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_set  (wr_set),
        .wr_idx  (wr_idx),
        .wr_ent  (wr_ent),
        .rd_set  (lk_data),
        .rd_view (view)
    );

    bat_match #(.N_ENT(N_ENT)) u_match (
        .view     (view),
        .addr     (lk_addr),
        .is_write (lk_write),
        .is_user  (lk_user),
        .qual     (qual),
        .wr_ok    (wr_ok),
        .pa       (pa)
    );

    bat_select #(.N_ENT(N_ENT)) u_sel (
        .qual   (qual),
        .wr_ok  (wr_ok),
        .pa     (pa),
        .hit    (hit),
        .sel_wr (sel_wr),
        .sel_pa (sel_pa)
    );

    // Register the response; misses and idle cycles carry zero rights.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_paddr <= '0;
            rsp_vpage <= '0;
            rsp_rd    <= 1'b0;
            rsp_wr    <= 1'b0;
            rsp_ex    <= 1'b0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && hit;
            rsp_paddr <= (lk_req && hit) ? sel_pa : '0;
            rsp_vpage <= {lk_vsid, lk_addr[PAGE_HI:PAGE_LO]};
            rsp_rd    <= lk_req && hit;
            rsp_wr    <= lk_req && hit && sel_wr;
            rsp_ex    <= lk_req && hit;
        end
    end
endmodule

// File: rtl/bat_xlate_checker.sv
// Property checks on the ports of the translation unit, bound to every instance.
module bat_xlate_checker
    import bat_pkg::*;
#(
    parameter int N_ENT  = N_ENT_DEF,
    parameter int VSID_W = VSID_W_DEF,
    localparam int VP_W  = VSID_W + VPN_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lk_req,
    input logic [ADDR_W-1:0]   lk_addr,
    input logic                lk_write,
    input logic [VSID_W-1:0]   lk_vsid,
    input logic                rsp_valid,
    input logic                rsp_hit,
    input logic [ADDR_W-1:0]   rsp_paddr,
    input logic [VP_W-1:0]     rsp_vpage,
    input logic                rsp_rd,
    input logic                rsp_wr,
    input logic                rsp_ex
);
    a_r11_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid);
    a_r11_no_resp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid);
    a_r9_vpage_tag: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_vpage == {$past(lk_vsid), $past(lk_addr[PAGE_HI:PAGE_LO])});
    a_r6_hit_reads_executes: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_rd && rsp_ex));
    a_r6_write_implies_read: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wr |-> rsp_rd);
    a_r7_store_hit_writable: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_write) |=> (!rsp_hit || rsp_wr));
    a_r10_miss_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && !rsp_rd && !rsp_wr && !rsp_ex));
endmodule

bind bat_xlate_unit bat_xlate_checker #(.N_ENT(N_ENT), .VSID_W(VSID_W)) u_chk (.*);

// File: tb/tb_bat_xlate_unit.sv
// Scoreboard bench: the driver queues expected responses, the monitor checks them.
module tb_bat_xlate_unit;
    import bat_pkg::*;

    localparam int N_ENT  = 8;
    localparam int VSID_W = 24;
    localparam int VP_W   = VSID_W + VPN_W;
    localparam int IDX_W  = $clog2(N_ENT);

    typedef struct {
        logic              hit;
        logic [ADDR_W-1:0] pa;
        logic [VP_W-1:0]   vp;
        logic              rd;
        logic              wr;
        string             tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_set = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [ADDR_W-1:0] wr_mask = '0, wr_epage = '0, wr_rpage = '0;
    logic wr_uvld = 1'b0, wr_svld = 1'b0;
    logic [PROT_W-1:0] wr_prot = '0;
    logic lk_req = 1'b0, lk_data = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic [VSID_W-1:0] lk_vsid = '0;
    logic rsp_valid, rsp_hit, rsp_rd, rsp_wr, rsp_ex;
    logic [ADDR_W-1:0] rsp_paddr;
    logic [VP_W-1:0] rsp_vpage;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;

    bat_xlate_unit #(.N_ENT(N_ENT), .VSID_W(VSID_W)) dut (.*);

    // Load one entry during one cycle.
    task automatic put_entry(input logic set, input int idx, input logic [31:0] mask,
                             input logic [31:0] ep, input logic [31:0] rp,
                             input logic uv, input logic sv, input logic [1:0] prot);
        @(negedge clk);
        wr_en = 1'b1; wr_set = set; wr_idx = IDX_W'(idx);
        wr_mask = mask; wr_epage = ep; wr_rpage = rp;
        wr_uvld = uv; wr_svld = sv; wr_prot = prot;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drive a lookup for one cycle and queue its expected response.
    task automatic lookup(input logic [31:0] a, input logic dat, input logic wrt,
                          input logic usr, input logic [VSID_W-1:0] vs,
                          input logic eh, input logic [31:0] epa,
                          input logic erd, input logic ewr, input string tag);
        exp_t e;
        e.hit = eh; e.pa = epa; e.rd = erd; e.wr = ewr; e.tag = tag;
        e.vp = {vs, a[27:12]};
        sb.push_back(e);
        lk_req = 1'b1; lk_addr = a; lk_data = dat; lk_write = wrt;
        lk_user = usr; lk_vsid = vs;
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    // Monitor: compare each response with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            n_tests++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R11 unexpected response act valid=1 exp valid=0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_hit !== e.hit || rsp_paddr !== e.pa || rsp_vpage !== e.vp ||
                    rsp_rd !== e.rd || rsp_wr !== e.wr || rsp_ex !== e.hit) begin
                    n_fail++;
                    $display("FAIL %s act hit=%b pa=%h vp=%h rd=%b wr=%b ex=%b exp hit=%b pa=%h vp=%h rd=%b wr=%b ex=%b",
                             e.tag, rsp_hit, rsp_paddr, rsp_vpage, rsp_rd, rsp_wr, rsp_ex,
                             e.hit, e.pa, e.vp, e.rd, e.wr, e.hit);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog act running exp done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: no response after reset, and lookups miss on cleared banks
        n_tests++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 act rsp_valid=%b exp 0", rsp_valid);
        end
        lookup(32'h1000_1234, 1, 0, 0, 24'hABCDEF, 0, 0, 0, 0, "R1 reset miss");
        lookup(32'h0000_0000, 0, 0, 1, 24'h000001, 0, 0, 0, 0, "R1 reset miss instr");

        // Data entry 0: 128 KiB block, supervisor only, read/write
        put_entry(1, 0, 32'hFFFE_0000, 32'h1000_0000, 32'h2000_0000, 0, 1, 2'd2);
        lookup(32'h1001_2345, 1, 0, 0, 24'h123456, 1, 32'h2001_2345, 1, 1, "R4 R5 R6 data hit");
        lookup(32'h1001_2345, 1, 0, 1, 24'h123456, 0, 0, 0, 0, "R3 user not eligible");
        lookup(32'h1001_2345, 0, 0, 0, 24'h123456, 0, 0, 0, 0, "R2 instr bank empty");

        // Instruction entry 0: 64 KiB block, user only, read only
        put_entry(0, 0, 32'hFFFF_0000, 32'h1000_0000, 32'h3000_0000, 1, 0, 2'd1);
        lookup(32'h1000_ABCD, 0, 0, 1, 24'h00FF00, 1, 32'h3000_ABCD, 1, 0, "R2 R6 instr read only");
        lookup(32'h1000_ABCD, 0, 1, 1, 24'h00FF00, 0, 0, 0, 0, "R7 store to read only skipped");
        lookup(32'h1000_ABCD, 0, 0, 0, 24'h00FF00, 0, 0, 0, 0, "R3 supervisor not eligible");

        // Data entry 1: 1 MiB block overlapping entry 0, both modes, code 3
        put_entry(1, 1, 32'hFFF0_0000, 32'h1000_0000, 32'h4000_0000, 1, 1, 2'd3);
        lookup(32'h1001_2345, 1, 1, 0, 24'h000777, 1, 32'h2001_2345, 1, 1, "R8 lowest index wins");
        lookup(32'h1001_2345, 1, 0, 1, 24'h000777, 1, 32'h4001_2345, 1, 1, "R3 R8 user falls to entry1");
        lookup(32'h100A_BCDE, 1, 0, 0, 24'h000777, 1, 32'h400A_BCDE, 1, 1, "R4 R5 outside entry0");

        // Data entry 0 rewritten with code 0: skipped, search continues
        put_entry(1, 0, 32'hFFFE_0000, 32'h1000_0000, 32'h2000_0000, 0, 1, 2'd0);
        lookup(32'h1001_2345, 1, 0, 0, 24'h000042, 1, 32'h4001_2345, 1, 1, "R7 code0 skipped");
        lookup(32'h5000_0000, 1, 0, 0, 24'hFFFFFF, 0, 0, 0, 0, "R10 R4 no match miss");

        // R12: write entry 2 and look it up in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_set = 1'b1; wr_idx = IDX_W'(2);
        wr_mask = 32'hFFFF_F000; wr_epage = 32'h6000_0000; wr_rpage = 32'h7000_0000;
        wr_uvld = 1'b0; wr_svld = 1'b1; wr_prot = 2'd2;
        lookup(32'h6000_0ABC, 1, 1, 0, 24'h0000AA, 0, 0, 0, 0, "R12 same-cycle sees old");
        wr_en = 1'b0;
        lookup(32'h6000_0ABC, 1, 1, 0, 24'h0000AA, 1, 32'h7000_0ABC, 1, 1, "R12 next lookup sees new");

        // R11: idle cycle produces no response
        @(negedge clk);
        n_tests++;
        if (rsp_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 idle act rsp_valid=%b exp 0", rsp_valid);
        end
        // R9 back-to-back requests carry their own tags
        lookup(32'h0FFF_F000, 1, 0, 0, 24'h135790, 0, 0, 0, 0, "R9 tag high page");
        lookup(32'h6000_0FFF, 1, 0, 0, 24'h02468A, 1, 32'h7000_0FFF, 1, 1, "R9 R11 back to back");

        repeat (3) @(negedge clk);
        n_tests++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R11 missing responses act %0d pending exp 0", sb.size());
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule